// File: doc/BRIEF.md
# Indexed Display Mode Register Port

This block gives a host a compact way to reach a sparse register space through two ports. One port loads an index register; the other port reads or writes the register that the held index points at. The stored state covers the device identity word, a display-on switch, the requested screen size, the pixel format check, a configured flag, a hardware cursor (identity, position, visibility), a busy handshake for command-buffer runs and a small bank of general scratch words.

Every value-port write is screened by the register it targets. Identity writes must name a known revision, screen sizes must stay inside fixed limits, and a non-native pixel size drops the configured state. A request to mark configuration as done is honoured only after the four command-buffer header words, taken from inputs that other logic supplies, pass alignment and range checks. Mode, cursor and status values leave the block as plain outputs, with one-cycle pulses for "screen must be redrawn" and "start a command run".

Top module: `idxreg_port`

## Requirements
- R1: Index 0 holds the identity word. It resets to 0x90000002 and takes a written value only when that value is 0x90000000, 0x90000001 or 0x90000002; any other value leaves it unchanged.
- R2: Width (index 2) accepts values up to 2360 and height (index 3) up to 1770. An accepted write updates the register and raises `inval_pulse` for one cycle; a larger value leaves the register unchanged and raises no pulse.
- R3: A write to index 1 sets the enable bit to 1 for any nonzero value and 0 for zero, and raises `inval_pulse` for one cycle.
- R4: A write to index 7 with a value other than 32 clears the configured flag and raises `inval_pulse`; a write of 32 changes nothing. Reads of index 7 and index 28 return 32.
- R5: A zero write to index 20 clears the configured flag. A nonzero write sets it only when min, max, next and stop are all multiples of 4, min is at least 16, max is at most 0x10000 and max is at least min + 10240; otherwise the flag is unchanged.
- R6: Index 6 reads 24 (depth for 32-bit pixels), index 12 reads width × 4 bytes, index 4 reads 2360 and index 5 reads 1770.
- R7: Indices 24, 25 and 26 store cursor identity, x and y. A write of 1 to index 27 makes the cursor visible, 0 hides it, and 2 or 3 leave visibility unchanged; index 27 reads the visibility.
- R8: A write to index 21 sets busy and raises `run_start` for one cycle; `run_done` clears busy; reads of index 21 or 22 return busy. When a sync write and `run_done` fall in the same cycle, busy stays set.
- R9: Indices 1024 to 1791 read 0 and ignore writes. Scratch words start at index 1792, store full 32-bit values, and index 29 reads the scratch count (8).
- R10: A read of an index outside every defined register returns 0 and sets the sticky `bad_idx` output.
- R11: Reset clears the index, enable, configured flag, cursor visibility, busy and `bad_idx`, and restores the identity word.
- R12: When the index and the value port are written in the same cycle, the value goes to the register named by the index held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| idx_wr | input | 1 | Load the index register |
| idx_wdata | input | IDX_W | New index value |
| val_wr | input | 1 | Write to the indexed register |
| val_rd | input | 1 | Read strobe for the indexed register |
| val_wdata | input | 32 | Value to write |
| val_rdata | output | 32 | Contents of the indexed register |
| hdr_min | input | 32 | Command-buffer lower bound, bytes |
| hdr_max | input | 32 | Command-buffer upper bound, bytes |
| hdr_next | input | 32 | Command-buffer producer offset |
| hdr_stop | input | 32 | Command-buffer consumer offset |
| run_done | input | 1 | Command run finished |
| dev_id | output | 32 | Identity word |
| mode_enable | output | 1 | Display mode on |
| mode_width | output | W_BITS | Requested width |
| mode_height | output | H_BITS | Requested height |
| cfg_done | output | 1 | Configured flag |
| inval_pulse | output | 1 | One-cycle redraw request |
| cursor_id | output | 32 | Cursor identity |
| cursor_x | output | CUR_W | Cursor x |
| cursor_y | output | CUR_W | Cursor y |
| cursor_vis | output | 1 | Cursor visible |
| busy | output | 1 | Command run pending |
| run_start | output | 1 | One-cycle run request |
| bad_idx | output | 1 | Sticky undefined-index read flag |

## Verification
Two pairs of events can land on the same edge: a sync write together with the completion strobe of the previous run, and an index load together with a value write. The bench drives each pair in a single cycle; for the first it judges that busy is still set and a new run pulse appears, for the second it reads back both the old and the new index to see that only the previously held register took the value.

// File: rtl/idxreg_pkg.sv
package idxreg_pkg;

    localparam int unsigned DATA_W = 32;

    localparam logic [31:0] ID_REV0 = 32'h9000_0000;
    localparam logic [31:0] ID_REV1 = 32'h9000_0001;
    localparam logic [31:0] ID_REV2 = 32'h9000_0002;

    // register indices whose numbers software depends on
    localparam int unsigned IX_ID       = 0;
    localparam int unsigned IX_ENABLE   = 1;
    localparam int unsigned IX_WIDTH    = 2;
    localparam int unsigned IX_HEIGHT   = 3;
    localparam int unsigned IX_MAXW     = 4;
    localparam int unsigned IX_MAXH     = 5;
    localparam int unsigned IX_DEPTH    = 6;
    localparam int unsigned IX_BPP      = 7;
    localparam int unsigned IX_PITCH    = 12;
    localparam int unsigned IX_CFG      = 20;
    localparam int unsigned IX_SYNC     = 21;
    localparam int unsigned IX_BUSY     = 22;
    localparam int unsigned IX_CUR_ID   = 24;
    localparam int unsigned IX_CUR_X    = 25;
    localparam int unsigned IX_CUR_Y    = 26;
    localparam int unsigned IX_CUR_ON   = 27;
    localparam int unsigned IX_HBPP     = 28;
    localparam int unsigned IX_SCR_CNT  = 29;
    localparam int unsigned IX_ZERO_LO  = 30;
    localparam int unsigned IX_ZERO_HI  = 32;
    localparam int unsigned IX_PAL_LO   = 1024;
    localparam int unsigned IX_PAL_HI   = 1791;
    localparam int unsigned IX_SCR_BASE = 1792;

    localparam logic [31:0] CUR_HIDE = 32'd0;
    localparam logic [31:0] CUR_SHOW = 32'd1;

    typedef enum logic [4:0] {
        K_ID, K_ENABLE, K_WIDTH, K_HEIGHT, K_MAXW, K_MAXH, K_DEPTH,
        K_BPP, K_HBPP, K_PITCH, K_CFG, K_SYNC, K_BUSY, K_CUR_ID,
        K_CUR_X, K_CUR_Y, K_CUR_ON, K_SCR_CNT, K_ZERO, K_PAL, K_SCR, K_BAD
    } reg_kind_e;

    typedef struct packed {
        logic [31:0] lo;
        logic [31:0] hi;
        logic [31:0] prod;
        logic [31:0] cons;
    } buf_hdr_t;

    function automatic logic id_is_legal(input logic [31:0] v);
        return (v == ID_REV0) || (v == ID_REV1) || (v == ID_REV2);
    endfunction

    function automatic logic [31:0] depth_view(input int unsigned bits);
        return (bits == 32) ? 32'd24 : 32'(bits);
    endfunction

endpackage

// File: rtl/idxreg_decode.sv
module idxreg_decode
    import idxreg_pkg::*;
#(
    parameter int IDX_W  = 16,
    parameter int N_SCR  = 8,
    parameter int SCR_AW = 3
) (
    input  logic [IDX_W-1:0]  idx,
    output reg_kind_e         kind,
    output logic [SCR_AW-1:0] scr_sel
);
    logic [31:0] ix;

    always_comb begin
        ix      = 32'(idx);
        kind    = K_BAD;
        scr_sel = '0;
        if (ix >= IX_PAL_LO && ix <= IX_PAL_HI) begin
            kind = K_PAL;
        end else if (ix >= IX_SCR_BASE && ix < IX_SCR_BASE + 32'(N_SCR)) begin
            kind    = K_SCR;
            scr_sel = SCR_AW'(ix - IX_SCR_BASE);
        end else if (ix >= IX_ZERO_LO && ix <= IX_ZERO_HI) begin
            kind = K_ZERO;
        end else begin
            case (ix)
                IX_ID:      kind = K_ID;
                IX_ENABLE:  kind = K_ENABLE;
                IX_WIDTH:   kind = K_WIDTH;
                IX_HEIGHT:  kind = K_HEIGHT;
                IX_MAXW:    kind = K_MAXW;
                IX_MAXH:    kind = K_MAXH;
                IX_DEPTH:   kind = K_DEPTH;
                IX_BPP:     kind = K_BPP;
                IX_PITCH:   kind = K_PITCH;
                IX_CFG:     kind = K_CFG;
                IX_SYNC:    kind = K_SYNC;
                IX_BUSY:    kind = K_BUSY;
                IX_CUR_ID:  kind = K_CUR_ID;
                IX_CUR_X:   kind = K_CUR_X;
                IX_CUR_Y:   kind = K_CUR_Y;
                IX_CUR_ON:  kind = K_CUR_ON;
                IX_HBPP:    kind = K_HBPP;
                IX_SCR_CNT: kind = K_SCR_CNT;
                default:    kind = K_BAD;
            endcase
        end
    end
endmodule

// File: rtl/idxreg_hdrchk.sv
module idxreg_hdrchk
    import idxreg_pkg::*;
#(
    parameter int BUF_BYTES = 65536,
    parameter int MIN_SPAN  = 10240,
    parameter int HDR_BYTES = 16
) (
    input  buf_hdr_t hdr,
    output logic     hdr_ok
);
    logic        aligned;
    logic        lo_ok;
    logic        hi_ok;
    logic        span_ok;
    logic [32:0] need_hi;

    always_comb begin
        aligned = ((hdr.lo | hdr.hi | hdr.prod | hdr.cons) & 32'h3) == 32'h0;
        lo_ok   = hdr.lo >= 32'(HDR_BYTES);
        hi_ok   = hdr.hi <= 32'(BUF_BYTES);
        need_hi = {1'b0, hdr.lo} + 33'(MIN_SPAN);
        span_ok = {1'b0, hdr.hi} >= need_hi;
        hdr_ok  = aligned && lo_ok && hi_ok && span_ok;
    end
endmodule

// File: rtl/idxreg_scratch.sv
module idxreg_scratch #(
    parameter int N  = 8,
    parameter int AW = 3,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] sel,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    logic [N-1:0][DW-1:0] bank;

    for (genvar g = 0; g < N; g++) begin : g_word
        logic [DW-1:0] word_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                word_q <= '0;
            end else if (we && sel == AW'(g)) begin
                word_q <= wdata;
            end
        end
        assign bank[g] = word_q;
    end

    assign rdata = bank[sel];
endmodule

// File: rtl/idxreg_port.sv
module idxreg_port
    import idxreg_pkg::*;
#(
    parameter int IDX_W     = 16,
    parameter int W_BITS    = 12,
    parameter int H_BITS    = 11,
    parameter int MAX_W     = 2360,
    parameter int MAX_H     = 1770,
    parameter int PIX_BITS  = 32,
    parameter int CUR_W     = 16,
    parameter int N_SCR     = 8,
    parameter int BUF_BYTES = 65536,
    parameter int MIN_SPAN  = 10240,
    parameter int HDR_BYTES = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              idx_wr,
    input  logic [IDX_W-1:0]  idx_wdata,
    input  logic              val_wr,
    input  logic              val_rd,
    input  logic [31:0]       val_wdata,
    output logic [31:0]       val_rdata,
    input  logic [31:0]       hdr_min,
    input  logic [31:0]       hdr_max,
    input  logic [31:0]       hdr_next,
    input  logic [31:0]       hdr_stop,
    input  logic              run_done,
    output logic [31:0]       dev_id,
    output logic              mode_enable,
    output logic [W_BITS-1:0] mode_width,
    output logic [H_BITS-1:0] mode_height,
    output logic              cfg_done,
    output logic              inval_pulse,
    output logic [31:0]       cursor_id,
    output logic [CUR_W-1:0]  cursor_x,
    output logic [CUR_W-1:0]  cursor_y,
    output logic              cursor_vis,
    output logic              busy,
    output logic              run_start,
    output logic              bad_idx
);
    localparam int SCR_AW = (N_SCR > 1) ? $clog2(N_SCR) : 1;

    logic [IDX_W-1:0]  cur_idx;
    logic [31:0]       id_q;
    logic              en_q;
    logic [W_BITS-1:0] wid_q;
    logic [H_BITS-1:0] hgt_q;
    logic              cfg_q;
    logic              busy_q;
    logic [31:0]       cid_q;
    logic [CUR_W-1:0]  cx_q;
    logic [CUR_W-1:0]  cy_q;
    logic              vis_q;
    logic              inval_q;
    logic              start_q;
    logic              bad_q;

    reg_kind_e         kind;
    logic [SCR_AW-1:0] scr_sel;
    logic [31:0]       scr_rdata;
    logic              hdr_ok;
    buf_hdr_t          hdr;
    logic [31:0]       pitch;

    assign hdr = '{lo: hdr_min, hi: hdr_max, prod: hdr_next, cons: hdr_stop};

    idxreg_decode #(.IDX_W(IDX_W), .N_SCR(N_SCR), .SCR_AW(SCR_AW)) dec_i (
        .idx     (cur_idx),
        .kind    (kind),
        .scr_sel (scr_sel)
    );

    idxreg_hdrchk #(.BUF_BYTES(BUF_BYTES), .MIN_SPAN(MIN_SPAN), .HDR_BYTES(HDR_BYTES)) hdr_i (
        .hdr    (hdr),
        .hdr_ok (hdr_ok)
    );

    idxreg_scratch #(.N(N_SCR), .AW(SCR_AW), .DW(32)) scr_i (
        .clk   (clk),
        .rst   (rst),
        .we    (val_wr && kind == K_SCR),
        .sel   (scr_sel),
        .wdata (val_wdata),
        .rdata (scr_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_idx <= '0;
            id_q    <= ID_REV2;
            en_q    <= 1'b0;
            wid_q   <= '0;
            hgt_q   <= '0;
            cfg_q   <= 1'b0;
            busy_q  <= 1'b0;
            cid_q   <= '0;
            cx_q    <= '0;
            cy_q    <= '0;
            vis_q   <= 1'b0;
            inval_q <= 1'b0;
            start_q <= 1'b0;
            bad_q   <= 1'b0;
        end else begin
            inval_q <= 1'b0;
            start_q <= 1'b0;
            if (idx_wr) begin
                cur_idx <= idx_wdata;
            end
            if (run_done) begin
                busy_q <= 1'b0;
            end
            if (val_rd && kind == K_BAD) begin
                bad_q <= 1'b1;
            end
            if (val_wr) begin
                case (kind)
                    K_ID: begin
                        if (id_is_legal(val_wdata)) id_q <= val_wdata;
                    end
                    K_ENABLE: begin
                        en_q    <= |val_wdata;
                        inval_q <= 1'b1;
                    end
                    K_WIDTH: begin
                        if (val_wdata <= 32'(MAX_W)) begin
                            wid_q   <= W_BITS'(val_wdata);
                            inval_q <= 1'b1;
                        end
                    end
                    K_HEIGHT: begin
                        if (val_wdata <= 32'(MAX_H)) begin
                            hgt_q   <= H_BITS'(val_wdata);
                            inval_q <= 1'b1;
                        end
                    end
                    K_BPP: begin
                        if (val_wdata != 32'(PIX_BITS)) begin
                            cfg_q   <= 1'b0;
                            inval_q <= 1'b1;
                        end
                    end
                    K_CFG: begin
                        if (val_wdata == 32'h0) begin
                            cfg_q <= 1'b0;
                        end else if (hdr_ok) begin
                            cfg_q <= 1'b1;
                        end
                    end
                    K_SYNC: begin
                        busy_q  <= 1'b1;
                        start_q <= 1'b1;
                    end
                    K_CUR_ID: cid_q <= val_wdata;
                    K_CUR_X:  cx_q  <= CUR_W'(val_wdata);
                    K_CUR_Y:  cy_q  <= CUR_W'(val_wdata);
                    K_CUR_ON: begin
                        if (val_wdata == CUR_SHOW) begin
                            vis_q <= 1'b1;
                        end else if (val_wdata == CUR_HIDE) begin
                            vis_q <= 1'b0;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign pitch = (32'(wid_q) * 32'(PIX_BITS)) >> 3;

    always_comb begin
        case (kind)
            K_ID:      val_rdata = id_q;
            K_ENABLE:  val_rdata = 32'(en_q);
            K_WIDTH:   val_rdata = 32'(wid_q);
            K_HEIGHT:  val_rdata = 32'(hgt_q);
            K_MAXW:    val_rdata = 32'(MAX_W);
            K_MAXH:    val_rdata = 32'(MAX_H);
            K_DEPTH:   val_rdata = depth_view(PIX_BITS);
            K_BPP:     val_rdata = 32'(PIX_BITS);
            K_HBPP:    val_rdata = 32'(PIX_BITS);
            K_PITCH:   val_rdata = pitch;
            K_CFG:     val_rdata = 32'(cfg_q);
            K_SYNC:    val_rdata = 32'(busy_q);
            K_BUSY:    val_rdata = 32'(busy_q);
            K_CUR_ID:  val_rdata = cid_q;
            K_CUR_X:   val_rdata = 32'(cx_q);
            K_CUR_Y:   val_rdata = 32'(cy_q);
            K_CUR_ON:  val_rdata = 32'(vis_q);
            K_SCR_CNT: val_rdata = 32'(N_SCR);
            K_SCR:     val_rdata = scr_rdata;
            default:   val_rdata = 32'h0;
        endcase
    end

    assign dev_id      = id_q;
    assign mode_enable = en_q;
    assign mode_width  = wid_q;
    assign mode_height = hgt_q;
    assign cfg_done    = cfg_q;
    assign inval_pulse = inval_q;
    assign cursor_id   = cid_q;
    assign cursor_x    = cx_q;
    assign cursor_y    = cy_q;
    assign cursor_vis  = vis_q;
    assign busy        = busy_q;
    assign run_start   = start_q;
    assign bad_idx     = bad_q;
endmodule

// File: rtl/idxreg_chk.sv
module idxreg_chk
    import idxreg_pkg::*;
#(
    parameter int IDX_W  = 16,
    parameter int W_BITS = 12,
    parameter int MAX_W  = 2360
) (
    input logic              clk,
    input logic              rst,
    input logic [IDX_W-1:0]  cur_idx,
    input logic              val_wr,
    input logic              val_rd,
    input logic [31:0]       val_wdata,
    input logic [31:0]       dev_id,
    input logic              mode_enable,
    input logic [W_BITS-1:0] mode_width,
    input logic              cfg_done,
    input logic              inval_pulse,
    input logic              cursor_vis,
    input logic              busy,
    input logic              run_start,
    input logic              bad_idx
);
    logic [31:0] ix;
    assign ix = 32'(cur_idx);

    assert_id_legal_R1: assert property (@(posedge clk) disable iff (rst)
        id_is_legal(dev_id));

    assert_width_reject_R2: assert property (@(posedge clk) disable iff (rst)
        (val_wr && ix == IX_WIDTH && val_wdata > 32'(MAX_W))
        |=> (mode_width == $past(mode_width)) && !inval_pulse);

    assert_bpp_drop_R4: assert property (@(posedge clk) disable iff (rst)
        (val_wr && ix == IX_BPP && val_wdata != 32'd32)
        |=> !cfg_done && inval_pulse);

    assert_cursor_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (val_wr && ix == IX_CUR_ON && (val_wdata == 32'd2 || val_wdata == 32'd3))
        |=> cursor_vis == $past(cursor_vis));

    assert_sync_busy_R8: assert property (@(posedge clk) disable iff (rst)
        (val_wr && ix == IX_SYNC) |=> busy && run_start);

    assert_bad_read_R10: assert property (@(posedge clk) disable iff (rst)
        (val_rd && ix >= 32'd33 && ix <= 32'd1023) |=> bad_idx);

    assert_reset_state_R11: assert property (@(posedge clk)
        rst |=> (cur_idx == '0) && !busy && !cfg_done && !cursor_vis
                && !mode_enable && !bad_idx);
endmodule

bind idxreg_port idxreg_chk #(.IDX_W(IDX_W), .W_BITS(W_BITS), .MAX_W(MAX_W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .cur_idx     (cur_idx),
    .val_wr      (val_wr),
    .val_rd      (val_rd),
    .val_wdata   (val_wdata),
    .dev_id      (dev_id),
    .mode_enable (mode_enable),
    .mode_width  (mode_width),
    .cfg_done    (cfg_done),
    .inval_pulse (inval_pulse),
    .cursor_vis  (cursor_vis),
    .busy        (busy),
    .run_start   (run_start),
    .bad_idx     (bad_idx)
);

// File: tb/idxreg_port_tb.sv
`timescale 1ns/1ps
module idxreg_port_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        idx_wr = 1'b0;
    logic [15:0] idx_wdata = '0;
    logic        val_wr = 1'b0;
    logic        val_rd = 1'b0;
    logic [31:0] val_wdata = '0;
    logic [31:0] val_rdata;
    logic [31:0] hdr_min = 32'd16;
    logic [31:0] hdr_max = 32'h10000;
    logic [31:0] hdr_next = 32'd16;
    logic [31:0] hdr_stop = 32'd16;
    logic        run_done = 1'b0;
    logic [31:0] dev_id;
    logic        mode_enable;
    logic [11:0] mode_width;
    logic [10:0] mode_height;
    logic        cfg_done;
    logic        inval_pulse;
    logic [31:0] cursor_id;
    logic [15:0] cursor_x;
    logic [15:0] cursor_y;
    logic        cursor_vis;
    logic        busy;
    logic        run_start;
    logic        bad_idx;

    int total = 0;
    int bad   = 0;
    logic saw_inval;
    logic saw_start;

    always #2 clk = ~clk;

    idxreg_port dut_i (
        .clk(clk), .rst(rst), .idx_wr(idx_wr), .idx_wdata(idx_wdata),
        .val_wr(val_wr), .val_rd(val_rd), .val_wdata(val_wdata), .val_rdata(val_rdata),
        .hdr_min(hdr_min), .hdr_max(hdr_max), .hdr_next(hdr_next), .hdr_stop(hdr_stop),
        .run_done(run_done), .dev_id(dev_id), .mode_enable(mode_enable),
        .mode_width(mode_width), .mode_height(mode_height), .cfg_done(cfg_done),
        .inval_pulse(inval_pulse), .cursor_id(cursor_id), .cursor_x(cursor_x),
        .cursor_y(cursor_y), .cursor_vis(cursor_vis), .busy(busy),
        .run_start(run_start), .bad_idx(bad_idx)
    );

    typedef struct packed {
        logic        rd;
        logic [15:0] ix;
        logic [31:0] dat;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 51;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 16'd0,    32'h9000_0002, 4'd11},
        '{1'b1, 16'd1,    32'd0,         4'd11},
        '{1'b1, 16'd20,   32'd0,         4'd11},
        '{1'b1, 16'd27,   32'd0,         4'd11},
        '{1'b1, 16'd22,   32'd0,         4'd11},
        '{1'b0, 16'd0,    32'h1234_5678, 4'd1},
        '{1'b1, 16'd0,    32'h9000_0002, 4'd1},
        '{1'b0, 16'd0,    32'h9000_0000, 4'd1},
        '{1'b1, 16'd0,    32'h9000_0000, 4'd1},
        '{1'b0, 16'd0,    32'h9000_0001, 4'd1},
        '{1'b1, 16'd0,    32'h9000_0001, 4'd1},
        '{1'b0, 16'd2,    32'd2360,      4'd2},
        '{1'b1, 16'd2,    32'd2360,      4'd2},
        '{1'b0, 16'd2,    32'd2361,      4'd2},
        '{1'b1, 16'd2,    32'd2360,      4'd2},
        '{1'b0, 16'd3,    32'd1771,      4'd2},
        '{1'b1, 16'd3,    32'd0,         4'd2},
        '{1'b0, 16'd3,    32'd1770,      4'd2},
        '{1'b1, 16'd3,    32'd1770,      4'd2},
        '{1'b1, 16'd6,    32'd24,        4'd6},
        '{1'b1, 16'd7,    32'd32,        4'd4},
        '{1'b1, 16'd28,   32'd32,        4'd4},
        '{1'b1, 16'd12,   32'd9440,      4'd6},
        '{1'b1, 16'd4,    32'd2360,      4'd6},
        '{1'b1, 16'd5,    32'd1770,      4'd6},
        '{1'b0, 16'd1,    32'd5,         4'd3},
        '{1'b1, 16'd1,    32'd1,         4'd3},
        '{1'b0, 16'd27,   32'd1,         4'd7},
        '{1'b1, 16'd27,   32'd1,         4'd7},
        '{1'b0, 16'd27,   32'd2,         4'd7},
        '{1'b1, 16'd27,   32'd1,         4'd7},
        '{1'b0, 16'd27,   32'd3,         4'd7},
        '{1'b1, 16'd27,   32'd1,         4'd7},
        '{1'b0, 16'd27,   32'd0,         4'd7},
        '{1'b1, 16'd27,   32'd0,         4'd7},
        '{1'b0, 16'd27,   32'd2,         4'd7},
        '{1'b1, 16'd27,   32'd0,         4'd7},
        '{1'b0, 16'd24,   32'd7,         4'd7},
        '{1'b1, 16'd24,   32'd7,         4'd7},
        '{1'b0, 16'd25,   32'd300,       4'd7},
        '{1'b1, 16'd25,   32'd300,       4'd7},
        '{1'b0, 16'd26,   32'd400,       4'd7},
        '{1'b1, 16'd26,   32'd400,       4'd7},
        '{1'b0, 16'd1024, 32'd5,         4'd9},
        '{1'b1, 16'd1024, 32'd0,         4'd9},
        '{1'b1, 16'd1791, 32'd0,         4'd9},
        '{1'b0, 16'd1792, 32'hDEAD_BEEF, 4'd9},
        '{1'b0, 16'd1799, 32'h0000_0055, 4'd9},
        '{1'b1, 16'd1792, 32'hDEAD_BEEF, 4'd9},
        '{1'b1, 16'd1799, 32'h0000_0055, 4'd9},
        '{1'b1, 16'd29,   32'd8,         4'd9}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic set_idx(input int i);
        @(negedge clk);
        idx_wr    = 1'b1;
        idx_wdata = 16'(i);
        @(negedge clk);
        idx_wr    = 1'b0;
    endtask

    task automatic put_val(input logic [31:0] v);
        @(negedge clk);
        val_wr    = 1'b1;
        val_wdata = v;
        @(negedge clk);
        val_wr    = 1'b0;
        saw_inval = inval_pulse;
        saw_start = run_start;
    endtask

    task automatic wr(input int i, input logic [31:0] v);
        set_idx(i);
        put_val(v);
    endtask

    task automatic rd(input int i, output logic [31:0] v);
        set_idx(i);
        v      = val_rdata;
        val_rd = 1'b1;
        @(negedge clk);
        val_rd = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // table walk covering R1 R2 R3 R4 R6 R7 R9 R11
        for (int k = 0; k < NV; k++) begin
            if (VECS[k].rd) begin
                rd(int'(VECS[k].ix), r);
                check($sformatf("R%0d idx %0d", VECS[k].req, VECS[k].ix), r, VECS[k].dat);
            end else begin
                wr(int'(VECS[k].ix), VECS[k].dat);
            end
        end

        // R10: defined accesses left the flag clear; an undefined read sets it
        check("R10 flag clear", 32'(bad_idx), 32'd0);
        rd(9, r);
        check("R10 undefined reads zero", r, 32'd0);
        check("R10 flag set", 32'(bad_idx), 32'd1);

        // R3 / R2: invalidate pulse behaviour
        wr(1, 32'd0);
        check("R3 enable off", 32'(mode_enable), 32'd0);
        check("R3 inval pulse", 32'(saw_inval), 32'd1);
        wr(2, 32'd4000);
        check("R2 rejected no pulse", 32'(saw_inval), 32'd0);
        check("R2 width held", 32'(mode_width), 32'd2360);
        wr(3, 32'd600);
        check("R2 accepted pulse", 32'(saw_inval), 32'd1);

        // R5: header screening
        hdr_next = 32'd18;
        wr(20, 32'd1);
        check("R5 misaligned", 32'(cfg_done), 32'd0);
        hdr_next = 32'd16; hdr_min = 32'd8;
        wr(20, 32'd1);
        check("R5 min too low", 32'(cfg_done), 32'd0);
        hdr_min = 32'd16; hdr_max = 32'h10004;
        wr(20, 32'd1);
        check("R5 max too high", 32'(cfg_done), 32'd0);
        hdr_max = 32'd10252;
        wr(20, 32'd1);
        check("R5 span short", 32'(cfg_done), 32'd0);
        hdr_max = 32'd10256;
        wr(20, 32'd1);
        check("R5 span exact", 32'(cfg_done), 32'd1);
        wr(20, 32'd0);
        check("R5 zero clears", 32'(cfg_done), 32'd0);
        hdr_max = 32'h10000;
        wr(20, 32'd1);
        check("R5 accepted", 32'(cfg_done), 32'd1);
        hdr_stop = 32'd2;
        wr(20, 32'd1);
        check("R5 bad header keeps flag", 32'(cfg_done), 32'd1);
        hdr_stop = 32'd16;

        // R4: pixel size screening
        wr(7, 32'd32);
        check("R4 native keeps cfg", 32'(cfg_done), 32'd1);
        check("R4 native no pulse", 32'(saw_inval), 32'd0);
        wr(7, 32'd16);
        check("R4 other drops cfg", 32'(cfg_done), 32'd0);
        check("R4 other pulses", 32'(saw_inval), 32'd1);

        // R8: sync / busy handshake and same-cycle completion
        wr(21, 32'd1);
        check("R8 run_start", 32'(saw_start), 32'd1);
        check("R8 busy set", 32'(busy), 32'd1);
        rd(22, r);
        check("R8 busy read", r, 32'd1);
        rd(21, r);
        check("R8 sync read", r, 32'd1);
        @(negedge clk); run_done = 1'b1;
        @(negedge clk); run_done = 1'b0;
        check("R8 done clears", 32'(busy), 32'd0);
        wr(21, 32'd1);
        @(negedge clk); run_done = 1'b1;
        @(negedge clk); run_done = 1'b0;
        set_idx(21);
        @(negedge clk);
        val_wr = 1'b1; val_wdata = 32'd1; run_done = 1'b1;
        @(negedge clk);
        val_wr = 1'b0; run_done = 1'b0;
        check("R8 collision busy", 32'(busy), 32'd1);
        check("R8 collision start", 32'(run_start), 32'd1);

        // R12: index and value written in the same cycle
        set_idx(2);
        @(negedge clk);
        idx_wr = 1'b1; idx_wdata = 16'd3; val_wr = 1'b1; val_wdata = 32'd100;
        @(negedge clk);
        idx_wr = 1'b0; val_wr = 1'b0;
        rd(2, r);
        check("R12 old index written", r, 32'd100);
        rd(3, r);
        check("R12 new index untouched", r, 32'd600);

        // R11: reset mid-operation
        wr(1, 32'd1);
        wr(27, 32'd1);
        wr(20, 32'd1);
        set_idx(5);
        @(negedge clk); rst = 1'b1;
        @(negedge clk);
        @(negedge clk); rst = 1'b0;
        check("R11 enable", 32'(mode_enable), 32'd0);
        check("R11 cfg", 32'(cfg_done), 32'd0);
        check("R11 cursor", 32'(cursor_vis), 32'd0);
        check("R11 busy", 32'(busy), 32'd0);
        check("R11 bad flag", 32'(bad_idx), 32'd0);
        check("R11 index zero reads id", val_rdata, 32'h9000_0002);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule